// File: doc/BRIEF.md
# Bus Status and Command Register

This block holds the 32-bit status and command word of a PCI-style bus interface. The upper half keeps sticky error flags. Qualified hardware event pulses set them. A configuration write clears a flag only when it writes a 1 to that bit. The upper half also carries read-only capability fields with fixed values. The lower half keeps the command enables that software can read and write. One of these enables is the parity-error response enable, and it gates one of the error flags.

The block takes one-cycle event pulses from the bus engine, each with role qualifiers telling whether the device was master or target at the time. It also takes a configuration write strobe with data and per-byte enables. The readback follows the registers without delay. A level interrupt request is raised from the parity-detected flag when an external enable allows it.

Top module: `bus_status_cmd_reg`

## Requirements
- R1: After a synchronous active-low reset every flag and enable is 0, the readback is 0x0280_0000, and `par_irq` is 0.
- R2: Bits 26:25 always read 01 and bit 23 always reads 1. Bits 22:16 and 15:9 always read 0. No write changes any of them.
- R3: The flags sit at these bits: parity detected 31, system error 30, master abort received 29, target abort received 28, target abort signalled 27, master data parity 24. A write with `cfg_be[3]`=1 and data bit = 1 clears the flag. Data bit 0, or `cfg_be[3]`=0, leaves it unchanged. Writing 1 to a clear flag leaves it 0.
- R4: A set flag stays 1 until a clearing write. Hardware events never clear a flag.
- R5: `ev_par_det` sets bit 31 whatever the value of the parity-response enable (command bit 6).
- R6: Bit 24 sets only when `is_master`=1, (`perr_self_rd` or `perr_tgt_wr`)=1, and command bit 6 holds 1 before that edge.
- R7: Bit 29 sets on `ev_mabort` only when `is_master`=1 and `ev_special`=0.
- R8: Bit 28 sets on `ev_tabort_rcv` only with `is_master`=1. Bit 27 sets on `ev_tabort_sig` only with `is_target`=1. Bit 30 sets on `ev_serr`.
- R9: A set event and a clearing write on the same flag in the same cycle leave the flag at 1.
- R10: `par_irq` equals bit 31 AND `par_irq_en` as a level. It drops as soon as bit 31 is cleared.
- R11: Command bits 8:0 are read/write. `cfg_be[0]` gates bits 7:0 and `cfg_be[1]` gates bit 8. A disabled lane keeps its bits.
- R12: An event or write in the cycle before a rising edge shows in the readback after that edge and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_par_det | input | 1 | Parity error detected this cycle |
| ev_serr | input | 1 | System error driven this cycle |
| ev_mabort | input | 1 | Transaction ended by master abort |
| ev_special | input | 1 | Current transaction is a special cycle |
| ev_tabort_rcv | input | 1 | Target abort seen from the addressed target |
| ev_tabort_sig | input | 1 | Target abort issued by this device |
| is_master | input | 1 | Device is bus master this cycle |
| is_target | input | 1 | Device is addressed target this cycle |
| perr_self_rd | input | 1 | Device drove a data parity error on a read |
| perr_tgt_wr | input | 1 | Target reported a data parity error on a write |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_be | input | 4 | Byte enables, bit n gates bits 8n+7:8n |
| par_irq_en | input | 1 | Parity interrupt enable |
| reg_rdata | output | 32 | Register readback |
| par_irq | output | 1 | Parity interrupt request (level) |

## Verification
A hardware set and a clearing write can land on the same flag in the same cycle. The bench makes this happen by pulsing `ev_par_det` in the same cycle as a write of 1 to bit 31 with lane 3 enabled. It expects the flag still to read 1 and the interrupt still to be high after the edge. The response enable and the master data parity event can also meet at one edge. The bench clears bit 6 with a write, then raises a qualified parity event, and expects bit 24 to stay 0.

// File: rtl/srq_pkg.sv
// Package: field positions and reset image shared by the status/command register.
// Assumes a 32-bit word: status in the upper half, command in the lower half.
package srq_pkg;
    localparam int NFLAGS   = 6;
    // flag index order: 0 parity det, 1 sys err, 2 m-abort, 3 t-abort rcv, 4 t-abort sig, 5 m-data parity
    localparam int FLAG_POS [NFLAGS] = '{31, 30, 29, 28, 27, 24};
    localparam int F_PDET   = 0;
    localparam int F_SERR   = 1;
    localparam int F_MABT   = 2;
    localparam int F_TABR   = 3;
    localparam int F_TABS   = 4;
    localparam int F_MDPE   = 5;
    localparam int DSEL_LO  = 25;
    localparam int FB2B_POS = 23;
    localparam logic [1:0] DSEL_MEDIUM = 2'b01;
endpackage

// File: rtl/srq_set_qual.sv
// Module: qualifies raw bus event pulses into per-flag set requests.
// Assumes event and role inputs are valid in the same cycle; the enable is the registered command bit.
module srq_set_qual
    import srq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_par_det,
    input  logic              ev_serr,
    input  logic              ev_mabort,
    input  logic              ev_special,
    input  logic              ev_tabort_rcv,
    input  logic              ev_tabort_sig,
    input  logic              is_master,
    input  logic              is_target,
    input  logic              perr_self_rd,
    input  logic              perr_tgt_wr,
    input  logic              perr_resp_en,
    output logic [NFLAGS-1:0] set_req
);
    // Purpose: map each event to its flag with its role and enable gating.
    always_comb begin
        set_req          = '0;
        set_req[F_PDET]  = ev_par_det;
        set_req[F_SERR]  = ev_serr;
        set_req[F_MABT]  = ev_mabort & is_master & ~ev_special;
        set_req[F_TABR]  = ev_tabort_rcv & is_master;
        set_req[F_TABS]  = ev_tabort_sig & is_target;
        set_req[F_MDPE]  = is_master & (perr_self_rd | perr_tgt_wr) & perr_resp_en;
    end

    // R6
    mdpe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_req[F_MDPE] |-> (perr_resp_en && is_master));
    // R7
    mabt_special_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_special |-> !set_req[F_MABT]);
    // R8
    tabs_role_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !is_target |-> !set_req[F_TABS]);
endmodule

// File: rtl/srq_w1c_bank.sv
// Module: bank of sticky flags, set by hardware and cleared by write-one.
// Assumes set and clear vectors are already qualified; set has priority.
module srq_w1c_bank #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_req,
    input  logic [N-1:0] clr_req,
    output logic [N-1:0] flags
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        // Purpose: hold one sticky flag; set beats clear in the same cycle.
        always_ff @(posedge clk) begin
            if (!rst_n)
                flags[i] <= 1'b0;
            else if (set_req[i])
                flags[i] <= 1'b1;
            else if (clr_req[i])
                flags[i] <= 1'b0;
        end

        // R9
        set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            set_req[i] |=> flags[i]);
        // R4
        sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (flags[i] && !clr_req[i]) |=> flags[i]);
        // R3
        clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_req[i] && !set_req[i]) |=> !flags[i]);
        // R3
        no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!flags[i] && !set_req[i]) |=> !flags[i]);
    end
endmodule

// File: rtl/srq_cmd_bank.sv
// Module: read/write command field with per-byte write enables.
// Assumes WIDTH is a multiple of 8; bits outside WMASK are reserved and read 0.
module srq_cmd_bank #(
    parameter int          WIDTH = 16,
    parameter logic [15:0] WMASK = 16'h01FF
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr,
    input  logic [WIDTH/8-1:0]   be,
    input  logic [WIDTH-1:0]     wdata,
    output logic [WIDTH-1:0]     q
);
    localparam int LANES = WIDTH / 8;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        localparam logic [7:0] LMASK = WMASK[8*l +: 8];
        // Purpose: update one byte lane when written, keeping reserved bits zero.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q[8*l +: 8] <= 8'h00;
            else if (wr && be[l])
                q[8*l +: 8] <= wdata[8*l +: 8] & LMASK;
        end

        // R11
        lane_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr && be[l]) |=> $stable(q[8*l +: 8]));
        // R11
        lane_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr && be[l]) |=> (q[8*l +: 8] == ($past(wdata[8*l +: 8]) & LMASK)));
    end
endmodule

// File: rtl/bus_status_cmd_reg.sv
// Module: top of the bus status/command register.
// Combines the sticky flags, the fixed capability fields and the command field.
// Assumes one synchronous clock domain and single-cycle event pulses.
module bus_status_cmd_reg
    import srq_pkg::*;
#(
    parameter int          CMD_WIDTH   = 16,
    parameter logic [15:0] CMD_WMASK   = 16'h01FF,
    parameter int          PERR_EN_BIT = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ev_par_det,
    input  logic        ev_serr,
    input  logic        ev_mabort,
    input  logic        ev_special,
    input  logic        ev_tabort_rcv,
    input  logic        ev_tabort_sig,
    input  logic        is_master,
    input  logic        is_target,
    input  logic        perr_self_rd,
    input  logic        perr_tgt_wr,
    input  logic        cfg_wr,
    input  logic [31:0] cfg_wdata,
    input  logic [3:0]  cfg_be,
    input  logic        par_irq_en,
    output logic [31:0] reg_rdata,
    output logic        par_irq
);
    localparam int CMD_LANES = CMD_WIDTH / 8;

    logic [NFLAGS-1:0]    set_req;
    logic [NFLAGS-1:0]    clr_req;
    logic [NFLAGS-1:0]    flags;
    logic [CMD_WIDTH-1:0] cmd_q;
    logic                 in_unused;

    assign in_unused = ^{cfg_wdata, cfg_be};

    srq_set_qual u_qual (
        .clk           (clk),
        .rst_n         (rst_n),
        .ev_par_det    (ev_par_det),
        .ev_serr       (ev_serr),
        .ev_mabort     (ev_mabort),
        .ev_special    (ev_special),
        .ev_tabort_rcv (ev_tabort_rcv),
        .ev_tabort_sig (ev_tabort_sig),
        .is_master     (is_master),
        .is_target     (is_target),
        .perr_self_rd  (perr_self_rd),
        .perr_tgt_wr   (perr_tgt_wr),
        .perr_resp_en  (cmd_q[PERR_EN_BIT]),
        .set_req       (set_req)
    );

    for (genvar f = 0; f < NFLAGS; f++) begin : g_clr
        localparam int POS = FLAG_POS[f];
        // Purpose: a clear needs the write strobe, the flag's byte lane and a 1 at its bit.
        always_comb clr_req[f] = cfg_wr & cfg_be[POS/8] & cfg_wdata[POS];
    end

    srq_w1c_bank #(.N(NFLAGS)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_req (set_req),
        .clr_req (clr_req),
        .flags   (flags)
    );

    srq_cmd_bank #(.WIDTH(CMD_WIDTH), .WMASK(CMD_WMASK)) u_cmd (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (cfg_wr),
        .be    (cfg_be[CMD_LANES-1:0]),
        .wdata (cfg_wdata[CMD_WIDTH-1:0]),
        .q     (cmd_q)
    );

    // Purpose: assemble the readback word from flags, fixed fields and command bits.
    always_comb begin
        reg_rdata                      = '0;
        reg_rdata[DSEL_LO +: 2]        = DSEL_MEDIUM;
        reg_rdata[FB2B_POS]            = 1'b1;
        for (int k = 0; k < NFLAGS; k++)
            reg_rdata[FLAG_POS[k]]     = flags[k];
        reg_rdata[CMD_WIDTH-1:0]       = cmd_q;
    end

    // Purpose: level interrupt from the parity-detected flag.
    assign par_irq = flags[F_PDET] & par_irq_en;

    // R10
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        par_irq |-> reg_rdata[31]);
    // R10
    irq_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[31] && par_irq_en) |-> par_irq);
    // R5
    pdet_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_par_det |=> reg_rdata[31]);
endmodule

// File: tb/tb_bus_status_cmd_reg.sv
module tb_bus_status_cmd_reg;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [9:0]  ev;
    logic        cfg_wr;
    logic [31:0] cfg_wdata;
    logic [3:0]  cfg_be;
    logic        par_irq_en;
    logic [31:0] reg_rdata;
    logic        par_irq;
    int          checks = 0;
    int          failures = 0;

    always #5 clk = ~clk;

    // ev bits: 9 par_det, 8 serr, 7 mabort, 6 special, 5 tabort_rcv, 4 tabort_sig,
    //          3 is_master, 2 is_target, 1 perr_self_rd, 0 perr_tgt_wr
    bus_status_cmd_reg dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .ev_par_det    (ev[9]),
        .ev_serr       (ev[8]),
        .ev_mabort     (ev[7]),
        .ev_special    (ev[6]),
        .ev_tabort_rcv (ev[5]),
        .ev_tabort_sig (ev[4]),
        .is_master     (ev[3]),
        .is_target     (ev[2]),
        .perr_self_rd  (ev[1]),
        .perr_tgt_wr   (ev[0]),
        .cfg_wr        (cfg_wr),
        .cfg_wdata     (cfg_wdata),
        .cfg_be        (cfg_be),
        .par_irq_en    (par_irq_en),
        .reg_rdata     (reg_rdata),
        .par_irq       (par_irq)
    );

    typedef struct packed {
        logic [9:0]  ev;
        logic        wr;
        logic [3:0]  be;
        logic [31:0] wd;
        logic        ien;
        logic [31:0] exp_rd;
        logic        exp_irq;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VT [NV] = '{
        '{10'h200, 1'b0, 4'h0, 32'h0000_0000, 1'b0, 32'h8280_0000, 1'b0, 8'd5 },  // R5 enable off
        '{10'h000, 1'b0, 4'h0, 32'h0000_0000, 1'b1, 32'h8280_0000, 1'b1, 8'd10},  // R10 R4
        '{10'h000, 1'b1, 4'h7, 32'hFFFF_FFFF, 1'b1, 32'h8280_01FF, 1'b1, 8'd11},  // R11 R2
        '{10'h000, 1'b1, 4'h8, 32'h0000_0000, 1'b1, 32'h8280_01FF, 1'b1, 8'd3 },  // R3 zero write
        '{10'h000, 1'b1, 4'h8, 32'h8000_0000, 1'b1, 32'h0280_01FF, 1'b0, 8'd3 },  // R3 R10 clear
        '{10'h000, 1'b1, 4'h8, 32'h4000_0000, 1'b1, 32'h0280_01FF, 1'b0, 8'd3 },  // R3 clear of clear flag
        '{10'h0C8, 1'b0, 4'h0, 32'h0000_0000, 1'b0, 32'h0280_01FF, 1'b0, 8'd7 },  // R7 special excluded
        '{10'h084, 1'b0, 4'h0, 32'h0000_0000, 1'b0, 32'h0280_01FF, 1'b0, 8'd7 },  // R7 not master
        '{10'h088, 1'b0, 4'h0, 32'h0000_0000, 1'b0, 32'h2280_01FF, 1'b0, 8'd7 },  // R7 sets
        '{10'h024, 1'b0, 4'h0, 32'h0000_0000, 1'b0, 32'h2280_01FF, 1'b0, 8'd8 },  // R8 rcv as target
        '{10'h018, 1'b0, 4'h0, 32'h0000_0000, 1'b0, 32'h2280_01FF, 1'b0, 8'd8 },  // R8 sig as master
        '{10'h028, 1'b0, 4'h0, 32'h0000_0000, 1'b0, 32'h3280_01FF, 1'b0, 8'd8 },  // R8 rcv sets
        '{10'h014, 1'b0, 4'h0, 32'h0000_0000, 1'b0, 32'h3A80_01FF, 1'b0, 8'd8 },  // R8 sig sets
        '{10'h100, 1'b0, 4'h0, 32'h0000_0000, 1'b0, 32'h7A80_01FF, 1'b0, 8'd8 },  // R8 serr
        '{10'h002, 1'b0, 4'h0, 32'h0000_0000, 1'b0, 32'h7A80_01FF, 1'b0, 8'd6 },  // R6 not master
        '{10'h009, 1'b0, 4'h0, 32'h0000_0000, 1'b0, 32'h7B80_01FF, 1'b0, 8'd6 },  // R6 sets
        '{10'h000, 1'b1, 4'h9, 32'h0100_00BF, 1'b0, 32'h7A80_01BF, 1'b0, 8'd11},  // R11 R3 lane mix
        '{10'h00A, 1'b0, 4'h0, 32'h0000_0000, 1'b0, 32'h7A80_01BF, 1'b0, 8'd6 },  // R6 enable off
        '{10'h200, 1'b0, 4'h0, 32'h0000_0000, 1'b0, 32'hFA80_01BF, 1'b0, 8'd5 },  // R5 enable off
        '{10'h200, 1'b1, 4'h8, 32'h8000_0000, 1'b1, 32'hFA80_01BF, 1'b1, 8'd9 },  // R9 set wins
        '{10'h000, 1'b1, 4'hF, 32'hFFFF_0000, 1'b1, 32'h0280_0000, 1'b0, 8'd3 },  // R3 clear all
        '{10'h000, 1'b1, 4'h3, 32'h0000_FFFF, 1'b0, 32'h0280_01FF, 1'b0, 8'd2 }   // R2 reserved stay 0
    };

    task automatic chk(input int req, input logic [31:0] act, input logic [31:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            failures++;
            $display("FAIL R%0d actual=%h expected=%h", req, act, exp_v);
        end
    endtask

    task automatic idle();
        ev = '0; cfg_wr = 1'b0; cfg_wdata = '0; cfg_be = '0;
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        idle();
        par_irq_en = 1'b1;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset image and interrupt
        chk(1, reg_rdata, 32'h0280_0000);
        chk(1, {31'd0, par_irq}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            ev = VT[i].ev; cfg_wr = VT[i].wr; cfg_be = VT[i].be;
            cfg_wdata = VT[i].wd; par_irq_en = VT[i].ien;
            @(negedge clk);
            chk(int'(VT[i].req), reg_rdata, VT[i].exp_rd);
            chk(int'(VT[i].req), {31'd0, par_irq}, {31'd0, VT[i].exp_irq});
        end
        idle();

        // R12 event is not visible before the edge, visible after it
        ev = 10'h200;
        #1;
        chk(12, reg_rdata, 32'h0280_01FF);
        @(negedge clk);
        chk(12, reg_rdata, 32'h8280_01FF);
        idle();

        // R10 interrupt follows the enable as a level
        par_irq_en = 1'b0;
        #1;
        chk(10, {31'd0, par_irq}, 32'd0);
        par_irq_en = 1'b1;
        #1;
        chk(10, {31'd0, par_irq}, 32'd1);

        // R2 fixed fields survive a write of zeros to every lane
        cfg_wr = 1'b1; cfg_be = 4'hF; cfg_wdata = 32'h0000_0000;
        @(negedge clk);
        chk(2, reg_rdata & 32'h06FF_FE00, 32'h0280_0000);
        idle();

        // R1 reset wins over events and writes in the same cycle
        rst_n = 1'b0; ev = 10'h3FF; cfg_wr = 1'b1; cfg_be = 4'hF; cfg_wdata = 32'hFFFF_FFFF;
        @(negedge clk);
        chk(1, reg_rdata, 32'h0280_0000);
        chk(1, {31'd0, par_irq}, 32'd0);
        idle();
        rst_n = 1'b1;
        @(negedge clk);
        // R4 nothing appears without an event
        chk(4, reg_rdata, 32'h0280_0000);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule